// File: doc/BRIEF.md
# Rectangular Blit Sequencer with Edge Masks

This block walks a rectangle of 16-bit words in memory, one line at a time. For each destination word it reads the old value over a request/acknowledge memory port, merges a result word supplied by a neighbouring logic unit under an edge mask, and writes the merged word back to the same address. The first word of every line uses one mask, the last word another, and all words between them a third. Partial words at the left and right edges of a rectangle are therefore protected while whole words in between are replaced.

Software programs signed step values, the rectangle size and the start addresses through a small register port. A write to the control register with the go bit set launches the walk. The block drives the current source address to the alignment unit that produces the result word. Between words of a line both addresses move by their x steps. After the last word of a line they move by their y steps. When the walk ends, the final addresses and a line count of zero stay readable.

Top module: `blit_seq`

## Requirements
- R1: The first word of each line is merged under the first mask, the last word under the last mask, and every other word under the middle mask. A line of one word uses only the first mask.
- R2: Each write stores (old & ~mask) | (result_i & mask), where old is the word just read from the same address.
- R3: Between words of a line, the source and destination addresses each advance by their own x step. After the last word of a line they advance by their y steps instead.
- R4: Addresses are 24 bits and always even. A write to a high address register keeps bits 7:0 as address bits 23:16. A write to a low register clears bit 0. mem_addr_o bit 0 is never set.
- R5: A walk starts only on a control write with bit 7 set while the line count is nonzero. The line count drops by one per finished line and ends at zero.
- R6: Control reads return busy in bit 7, the hog flag in bit 6, the smudge flag in bit 5, 0 in bit 4 and the halftone line number in bits 3:0. A written bit 4 is discarded.
- R7: Steps are signed 16-bit two's complement values. The final source and destination addresses stay in their registers after the walk.
- R8: Control bit 7 and busy_o read 1 while a walk runs and clear on completion. At the same moment done_o pulses high for one cycle.
- R9: Each word costs one read followed by one write at the same address. mem_req_o, mem_addr_o and mem_we_o hold until mem_ack_i. A walk of X words by Y lines makes exactly X*Y reads and X*Y writes.
- R10: Register writes while a walk runs are ignored.
- R11: The register select map is 0 source x step, 1 source y step, 2 source address high, 3 source address low, 4 first mask, 5 middle mask, 6 last mask, 7 destination x step, 8 destination y step, 9 destination address high, 10 destination address low, 11 words per line, 12 line count, 13 control. Reads return the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| result_i | input | 16 | Result word from the logic unit |
| src_addr_o | output | 24 | Current source address for the alignment unit |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 24 | Memory word address (even) |
| mem_wdata_o | output | 16 | Merged write data |
| mem_rdata_i | input | 16 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Access complete |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets single-word lines, where a design that picks the last mask, or lets it override the first, corrupts the protected bits. It also runs lines with negative steps, where a design without sign extension jumps far outside the rectangle and leaves the final address register wrong. Odd addresses written by software must land on the even word below; a design that keeps bit 0 writes to the wrong word. The bench also tries a go write with a zero line count and writes made during a walk. A design that starts anyway, or accepts those writes, shows extra memory traffic or a changed final address.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RG_SRC_XINC   = 4'd0;
  localparam logic [REG_AW-1:0] RG_SRC_YINC   = 4'd1;
  localparam logic [REG_AW-1:0] RG_SRC_HI     = 4'd2;
  localparam logic [REG_AW-1:0] RG_SRC_LO     = 4'd3;
  localparam logic [REG_AW-1:0] RG_MASK_FIRST = 4'd4;
  localparam logic [REG_AW-1:0] RG_MASK_MID   = 4'd5;
  localparam logic [REG_AW-1:0] RG_MASK_LAST  = 4'd6;
  localparam logic [REG_AW-1:0] RG_DST_XINC   = 4'd7;
  localparam logic [REG_AW-1:0] RG_DST_YINC   = 4'd8;
  localparam logic [REG_AW-1:0] RG_DST_HI     = 4'd9;
  localparam logic [REG_AW-1:0] RG_DST_LO     = 4'd10;
  localparam logic [REG_AW-1:0] RG_XCNT       = 4'd11;
  localparam logic [REG_AW-1:0] RG_YCNT       = 4'd12;
  localparam logic [REG_AW-1:0] RG_CTRL       = 4'd13;

  localparam int CTRL_GO_BIT     = 7;
  localparam int CTRL_HOG_BIT    = 6;
  localparam int CTRL_SMUDGE_BIT = 5;
  localparam int LINE_W          = 4;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_READ  = 2'd1,
    W_WRITE = 2'd2
  } walk_st_e;
endpackage

// File: rtl/blit_addr_step.sv
module blit_addr_step #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic [AW-1:0]        base_i,
  input  logic signed [CW-1:0] inc_i,
  output logic [AW-1:0]        next_o
);
  logic [AW-1:0] ext;
  logic [AW-1:0] sum;

  always_comb begin
    ext    = {{(AW-CW){inc_i[CW-1]}}, inc_i};
    sum    = base_i + ext;
    next_o = {sum[AW-1:1], 1'b0};
  end
endmodule

// File: rtl/blit_cfg_regs.sv
module blit_cfg_regs
  import blit_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 busy_i,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic signed [CW-1:0] src_xinc_o,
  output logic signed [CW-1:0] src_yinc_o,
  output logic signed [CW-1:0] dst_xinc_o,
  output logic signed [CW-1:0] dst_yinc_o,
  output logic [CW-1:0]        xcnt_o,
  output logic [DW-1:0]        mask_first_o,
  output logic [DW-1:0]        mask_mid_o,
  output logic [DW-1:0]        mask_last_o,
  output logic                 hog_o,
  output logic                 smudge_o,
  output logic [LINE_W-1:0]    line_o
);
  logic wr_ok;
  assign wr_ok = reg_we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_xinc_o   <= '0;
      src_yinc_o   <= '0;
      dst_xinc_o   <= '0;
      dst_yinc_o   <= '0;
      xcnt_o       <= '0;
      mask_first_o <= '0;
      mask_mid_o   <= '0;
      mask_last_o  <= '0;
      hog_o        <= 1'b0;
      smudge_o     <= 1'b0;
      line_o       <= '0;
    end else if (wr_ok) begin
      case (reg_addr_i)
        RG_SRC_XINC:   src_xinc_o   <= reg_wdata_i[CW-1:0];
        RG_SRC_YINC:   src_yinc_o   <= reg_wdata_i[CW-1:0];
        RG_DST_XINC:   dst_xinc_o   <= reg_wdata_i[CW-1:0];
        RG_DST_YINC:   dst_yinc_o   <= reg_wdata_i[CW-1:0];
        RG_XCNT:       xcnt_o       <= reg_wdata_i[CW-1:0];
        RG_MASK_FIRST: mask_first_o <= reg_wdata_i;
        RG_MASK_MID:   mask_mid_o   <= reg_wdata_i;
        RG_MASK_LAST:  mask_last_o  <= reg_wdata_i;
        RG_CTRL: begin
          // bit 4 has no storage
          hog_o    <= reg_wdata_i[CTRL_HOG_BIT];
          smudge_o <= reg_wdata_i[CTRL_SMUDGE_BIT];
          line_o   <= reg_wdata_i[LINE_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // R10
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(mask_first_o) && $stable(xcnt_o) && $stable(dst_xinc_o));
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  input  logic signed [CW-1:0] src_xinc_i,
  input  logic signed [CW-1:0] src_yinc_i,
  input  logic signed [CW-1:0] dst_xinc_i,
  input  logic signed [CW-1:0] dst_yinc_i,
  input  logic [CW-1:0]        xcnt_i,
  input  logic [DW-1:0]        mask_first_i,
  input  logic [DW-1:0]        mask_mid_i,
  input  logic [DW-1:0]        mask_last_i,
  input  logic [DW-1:0]        result_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o,
  input  logic [DW-1:0]        mem_rdata_i,
  input  logic                 mem_ack_i,
  output logic [AW-1:0]        src_addr_o,
  output logic [AW-1:0]        dst_addr_o,
  output logic [CW-1:0]        ycnt_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam int HIW   = AW - DW;
  localparam int NCHAN = 2;

  walk_st_e      st_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] ycnt_q, wcnt_q;
  logic [DW-1:0] rd_q;
  logic          first_q, done_q;

  logic                 line_end;
  logic                 start;
  logic [DW-1:0]        mask_sel;
  logic [AW-1:0]        step_base [NCHAN];
  logic signed [CW-1:0] step_inc  [NCHAN];
  logic [AW-1:0]        step_next [NCHAN];

  always_comb begin
    line_end     = (wcnt_q == CW'(1));
    step_base[0] = src_q;
    step_base[1] = dst_q;
    step_inc[0]  = line_end ? src_yinc_i : src_xinc_i;
    step_inc[1]  = line_end ? dst_yinc_i : dst_xinc_i;
    // first mask wins on a one-word line
    if (first_q)       mask_sel = mask_first_i;
    else if (line_end) mask_sel = mask_last_i;
    else               mask_sel = mask_mid_i;
  end

  for (genvar g = 0; g < NCHAN; g++) begin : g_step
    blit_addr_step #(.AW(AW), .CW(CW)) u_step (
      .base_i (step_base[g]),
      .inc_i  (step_inc[g]),
      .next_o (step_next[g])
    );
  end

  assign start = (st_q == W_IDLE) && reg_we_i && (reg_addr_i == RG_CTRL) &&
                 reg_wdata_i[CTRL_GO_BIT] && (ycnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= W_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      ycnt_q  <= '0;
      wcnt_q  <= '0;
      rd_q    <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        W_IDLE: begin
          if (reg_we_i) begin
            case (reg_addr_i)
              RG_SRC_HI: src_q[AW-1:DW] <= reg_wdata_i[HIW-1:0];
              RG_SRC_LO: src_q[DW-1:0]  <= {reg_wdata_i[DW-1:1], 1'b0};
              RG_DST_HI: dst_q[AW-1:DW] <= reg_wdata_i[HIW-1:0];
              RG_DST_LO: dst_q[DW-1:0]  <= {reg_wdata_i[DW-1:1], 1'b0};
              RG_YCNT:   ycnt_q         <= reg_wdata_i[CW-1:0];
              default: ;
            endcase
          end
          if (start) begin
            st_q    <= W_READ;
            wcnt_q  <= xcnt_i;
            first_q <= 1'b1;
          end
        end
        W_READ: begin
          if (mem_ack_i) begin
            rd_q <= mem_rdata_i;
            st_q <= W_WRITE;
          end
        end
        W_WRITE: begin
          if (mem_ack_i) begin
            src_q <= step_next[0];
            dst_q <= step_next[1];
            if (line_end) begin
              ycnt_q  <= ycnt_q - CW'(1);
              wcnt_q  <= xcnt_i;
              first_q <= 1'b1;
              if (ycnt_q == CW'(1)) begin
                st_q   <= W_IDLE;
                done_q <= 1'b1;
              end else begin
                st_q <= W_READ;
              end
            end else begin
              wcnt_q  <= wcnt_q - CW'(1);
              first_q <= 1'b0;
              st_q    <= W_READ;
            end
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == W_READ) || (st_q == W_WRITE);
  assign mem_we_o    = (st_q == W_WRITE);
  assign mem_addr_o  = dst_q;
  assign mem_wdata_o = (rd_q & ~mask_sel) | (result_i & mask_sel);
  assign src_addr_o  = src_q;
  assign dst_addr_o  = dst_q;
  assign ycnt_o      = ycnt_q;
  assign busy_o      = (st_q != W_IDLE);
  assign done_o      = done_q;

  // R4
  even_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_addr_o[0]);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R9
  write_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i |=> mem_we_o && $stable(mem_addr_o));

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R5
  ycnt_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> ycnt_q <= $past(ycnt_q));

  // R5
  start_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(ycnt_q) != '0);
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [DW-1:0]     result_i,
  output logic [AW-1:0]     src_addr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int HIW = AW - DW;

  logic signed [CW-1:0] src_xinc, src_yinc, dst_xinc, dst_yinc;
  logic [CW-1:0]        xcnt, ycnt;
  logic [DW-1:0]        mask_first, mask_mid, mask_last;
  logic                 hog, smudge, busy;
  logic [LINE_W-1:0]    line;
  logic [AW-1:0]        src_addr, dst_addr;

  blit_cfg_regs #(.DW(DW), .CW(CW)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .src_xinc_o   (src_xinc),
    .src_yinc_o   (src_yinc),
    .dst_xinc_o   (dst_xinc),
    .dst_yinc_o   (dst_yinc),
    .xcnt_o       (xcnt),
    .mask_first_o (mask_first),
    .mask_mid_o   (mask_mid),
    .mask_last_o  (mask_last),
    .hog_o        (hog),
    .smudge_o     (smudge),
    .line_o       (line)
  );

  blit_walker #(.AW(AW), .DW(DW), .CW(CW)) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .src_xinc_i   (src_xinc),
    .src_yinc_i   (src_yinc),
    .dst_xinc_i   (dst_xinc),
    .dst_yinc_i   (dst_yinc),
    .xcnt_i       (xcnt),
    .mask_first_i (mask_first),
    .mask_mid_i   (mask_mid),
    .mask_last_i  (mask_last),
    .result_i     (result_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_ack_i    (mem_ack_i),
    .src_addr_o   (src_addr),
    .dst_addr_o   (dst_addr),
    .ycnt_o       (ycnt),
    .busy_o       (busy),
    .done_o       (done_o)
  );

  always_comb begin
    case (reg_addr_i)
      RG_SRC_XINC:   reg_rdata_o = DW'(src_xinc);
      RG_SRC_YINC:   reg_rdata_o = DW'(src_yinc);
      RG_SRC_HI:     reg_rdata_o = {{(DW-HIW){1'b0}}, src_addr[AW-1:DW]};
      RG_SRC_LO:     reg_rdata_o = src_addr[DW-1:0];
      RG_MASK_FIRST: reg_rdata_o = mask_first;
      RG_MASK_MID:   reg_rdata_o = mask_mid;
      RG_MASK_LAST:  reg_rdata_o = mask_last;
      RG_DST_XINC:   reg_rdata_o = DW'(dst_xinc);
      RG_DST_YINC:   reg_rdata_o = DW'(dst_yinc);
      RG_DST_HI:     reg_rdata_o = {{(DW-HIW){1'b0}}, dst_addr[AW-1:DW]};
      RG_DST_LO:     reg_rdata_o = dst_addr[DW-1:0];
      RG_XCNT:       reg_rdata_o = DW'(xcnt);
      RG_YCNT:       reg_rdata_o = DW'(ycnt);
      RG_CTRL:       reg_rdata_o = {{(DW-8){1'b0}}, busy, hog, smudge, 1'b0, line};
      default:       reg_rdata_o = '0;
    endcase
  end

  assign src_addr_o = src_addr;
  assign busy_o     = busy;

  // R6
  ctrl_bit4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == RG_CTRL) |-> !reg_rdata_o[4]);
endmodule

// File: tb/test_blit_seq.sv
module test_blit_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [15:0] result_i;
  logic [23:0] src_addr_o;
  logic        mem_req_o, mem_we_o;
  logic [23:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i;
  logic        mem_ack_i;
  logic        busy_o, done_o;

  logic [15:0] mem [0:4095];
  logic [15:0] exp_mem [0:4095];
  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  int exp_src, exp_dst;

  always #10 clk_i = ~clk_i;

  assign result_i = src_addr_o[15:0] ^ 16'hC3C3;

  blit_seq i_blit_seq (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .result_i, .src_addr_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ack_i, .busy_o, .done_o
  );

  initial begin
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      if (mem_req_o && !mem_ack_i) begin
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          mem[mem_addr_o[12:1]] = mem_wdata_o;
          wr_cnt++;
        end else begin
          mem_rdata_i = mem[mem_addr_o[12:1]];
          rd_cnt++;
        end
      end else begin
        mem_ack_i = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk_i);
    if (done_o) done_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = int'(reg_rdata_o);
  endtask

  task automatic cfg(input int sa, input int da, input int sxi, input int syi,
                     input int dxi, input int dyi, input int xc, input int yc,
                     input int m1, input int m2, input int m3);
    wr(4'd0, 16'(sxi)); wr(4'd1, 16'(syi));
    wr(4'd2, 16'(sa >> 16)); wr(4'd3, 16'(sa));
    wr(4'd4, 16'(m1)); wr(4'd5, 16'(m2)); wr(4'd6, 16'(m3));
    wr(4'd7, 16'(dxi)); wr(4'd8, 16'(dyi));
    wr(4'd9, 16'(da >> 16)); wr(4'd10, 16'(da));
    wr(4'd11, 16'(xc)); wr(4'd12, 16'(yc));
  endtask

  // Reference walk built from R1-style rules, run before the block does it
  task automatic model(input int sa, input int da, input int sxi, input int syi,
                       input int dxi, input int dyi, input int xc, input int yc,
                       input int m1, input int m2, input int m3);
    int s, d, m;
    logic [15:0] r;
    for (int i = 0; i < 4096; i++) exp_mem[i] = mem[i];
    s = sa & 'hFFFFFE;
    d = da & 'hFFFFFE;
    for (int y = 0; y < yc; y++) begin
      for (int x = 0; x < xc; x++) begin
        if (x == 0) m = m1;
        else if (x == xc - 1) m = m3;
        else m = m2;
        r = 16'(s) ^ 16'hC3C3;
        exp_mem[d[12:1]] = (exp_mem[d[12:1]] & ~16'(m)) | (r & 16'(m));
        if (x == xc - 1) begin
          s = (s + syi) & 'hFFFFFE;
          d = (d + dyi) & 'hFFFFFE;
        end else begin
          s = (s + sxi) & 'hFFFFFE;
          d = (d + dxi) & 'hFFFFFE;
        end
      end
    end
    exp_src = s;
    exp_dst = d;
  endtask

  task automatic go(input logic [15:0] ctrl);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    wr(4'd13, ctrl);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000 && done_cnt == 0; i++) @(negedge clk_i);
  endtask

  task automatic cmp_mem(input string req);
    int mism = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk(req, mism, 0);
  endtask

  task automatic read_addr(input logic [3:0] hi, input logic [3:0] lo, output int a);
    int h, l;
    rd(hi, h); rd(lo, l);
    a = (h << 16) | l;
  endtask

  task automatic t_reset();
    int v;
    chk("R8 busy after reset", int'(busy_o), 0);
    rd(4'd13, v); chk("R6 ctrl after reset", v, 0);
    rd(4'd10, v); chk("R11 dst lo after reset", v, 0);
  endtask

  task automatic t_single();
    cfg('h100, 'h400, 2, 2, 2, 2, 1, 1, 'hF0F0, 'hFFFF, 'h0F0F);
    model('h100, 'h400, 2, 2, 2, 2, 1, 1, 'hF0F0, 'hFFFF, 'h0F0F);
    go(16'h0080);
    wait_done();
    cmp_mem("R1 one-word line uses first mask only");
    chk("R9 single reads", rd_cnt, 1);
    chk("R9 single writes", wr_cnt, 1);
    chk("R8 single done pulses", done_cnt, 1);
  endtask

  task automatic t_wide();
    int v;
    cfg('h200, 'h800, 2, 8, 2, 32, 4, 3, 'h00FF, 'hAAAA, 'hFF00);
    model('h200, 'h800, 2, 8, 2, 32, 4, 3, 'h00FF, 'hAAAA, 'hFF00);
    go(16'h0080);
    wait_done();
    cmp_mem("R2 merged words 4x3");
    chk("R9 wide reads", rd_cnt, 12);
    chk("R9 wide writes", wr_cnt, 12);
    read_addr(4'd9, 4'd10, v); chk("R3 final dst", v, exp_dst);
    read_addr(4'd2, 4'd3, v);  chk("R3 final src", v, exp_src);
    rd(4'd12, v); chk("R5 line count zero", v, 0);
    rd(4'd5, v);  chk("R11 mid mask readback", v, 'hAAAA);
  endtask

  task automatic t_negative();
    int v;
    cfg('h300, 'h1800, -4, 100, -2, -64, 3, 2, 'h3C3C, 'hFFFF, 'h8001);
    model('h300, 'h1800, -4, 100, -2, -64, 3, 2, 'h3C3C, 'hFFFF, 'h8001);
    go(16'h0080);
    wait_done();
    cmp_mem("R7 negative steps");
    read_addr(4'd9, 4'd10, v); chk("R7 final dst negative", v, exp_dst);
    read_addr(4'd2, 4'd3, v);  chk("R7 final src", v, exp_src);
  endtask

  task automatic t_odd();
    int v;
    wr(4'd9, 16'hAB12); wr(4'd10, 16'h3457);
    rd(4'd9, v);  chk("R4 dst high keeps 8 bits", v, 'h12);
    rd(4'd10, v); chk("R4 dst low forced even", v, 'h3456);
    cfg('h0501, 'h0201, 2, 2, 2, 2, 2, 1, 'hFFFF, 'hFFFF, 'h00F0);
    model('h0501, 'h0201, 2, 2, 2, 2, 2, 1, 'hFFFF, 'hFFFF, 'h00F0);
    go(16'h0080);
    wait_done();
    cmp_mem("R4 odd start lands on even word");
  endtask

  task automatic t_ctrl();
    int v;
    cfg('h700, 'h600, 2, 2, 2, 2, 2, 0, 'hFFFF, 'hFFFF, 'hFFFF);
    go(16'h00FF);
    repeat (10) @(negedge clk_i);
    chk("R5 no start with zero lines", wr_cnt + done_cnt + int'(busy_o), 0);
    rd(4'd13, v); chk("R6 ctrl bit4 dropped", v, 'h6F);
    wr(4'd12, 16'd2);
    go(16'h007F);
    repeat (10) @(negedge clk_i);
    chk("R5 no start without go bit", wr_cnt + int'(busy_o), 0);
    cfg('h700, 'h600, 2, 2, 2, 2, 2, 1, 'h0FF0, 'hFFFF, 'hF00F);
    model('h700, 'h600, 2, 2, 2, 2, 2, 1, 'h0FF0, 'hFFFF, 'hF00F);
    go(16'h00A3);
    rd(4'd13, v); chk("R8 busy bit while running", v, 'hA3);
    wr(4'd10, 16'h0F00);
    wr(4'd4, 16'h1234);
    wait_done();
    cmp_mem("R10 walk unaffected by writes");
    rd(4'd10, v); chk("R10 dst write ignored while busy", v, exp_dst & 'hFFFF);
    rd(4'd4, v);  chk("R10 mask write ignored while busy", v, 'h0FF0);
    rd(4'd13, v); chk("R8 busy bit cleared", v, 'h23);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 16'h1357) ^ 16'h8001;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_wide();
    t_negative();
    t_odd();
    t_ctrl();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule